// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test passes. It takes a 6-bit predicate code and the current floating-point status word. It reads the negative, zero and not-a-number condition flags from that word and returns a single true/false answer. Branch, set-on-condition and trap-on-condition sequencers all use this answer. The evaluation is purely combinational, so the answer is valid in the same cycle the predicate is presented.

Each 4-bit condition code is split into three parts:

- a NaN-gating bit;
- a two-bit sign-term selector;
- a zero OR/AND bit.

A fifth predicate bit marks tests that are not aware of unordered operands. When such a test sees a NaN, the block raises the branch-on-unordered exception flag in the status word, and with it the accrued invalid-operation flag.

Predicate codes of 32 and above are illegal. They are reported on a separate flag, and such a code never changes the status word. The updated status word is offered combinationally. It is also written into an output register when the sequencer pulses the update strobe.

Top module: `fp_cond_eval`

## Requirements
- R1: A predicate with bit 5 set (value 0x20 or above) drives `illegal_o` high and `cond_true_o` low; predicates 0x00 to 0x1F drive `illegal_o` low.
- R2: When `update_i` is high with an illegal predicate, `stat_q_o` keeps its previous value, and `stat_next_o` equals `stat_i`.
- R3: With predicate bit 3 clear, the base term is NOT NaN, where NaN is status bit 24. A set NaN flag can then only yield true through the zero OR term.
- R4: With predicate bit 3 set, the base term is 1 and the NaN flag is ORed into the final result, so any such predicate is true when NaN is set.
- R5: Predicate bits 2:1 choose the term ANDed with the base: 00 gives 0, 01 gives NOT negative (status bit 27), 10 gives negative, and 11 gives 1.
- R6: With predicate bit 0 clear, the result is ANDed with NOT zero (status bit 26). With bit 0 set, zero is ORed in, and this happens before the NaN OR of R4.
- R7: Condition 0000 is never true and condition 1111 is always true, whatever the flags. Condition 0001 equals the zero flag, and condition 1110 is true for NOT zero OR NaN.
- R8: With predicate bit 4 set, a legal predicate and NaN set, `stat_next_o` has the branch-on-unordered bit (bit 15) set.
- R9: Whenever bit 15 of `stat_next_o` is set, bit 7 (accrued invalid operation) of `stat_next_o` is also set. This holds whether bit 15 was newly raised or was already set in `stat_i`.
- R10: Apart from bits 15 and 7 as raised by R8 and R9, `stat_next_o` equals `stat_i`. With predicate bit 4 clear, bit 15 is passed through unchanged.
- R11: `stat_q_o` resets to 0, loads `stat_next_o` on the clock edge where `update_i` is high and the predicate is legal, and otherwise holds.
- R12: With bit 4 set, the true/false result depends only on predicate bits 3:0, and equals the result of the same code with bit 4 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pred_i | input | 6 | Predicate code |
| stat_i | input | 32 | Current status word |
| update_i | input | 1 | Strobe that writes the updated status into `stat_q_o` |
| cond_true_o | output | 1 | Predicate evaluates true |
| illegal_o | output | 1 | Predicate code out of range |
| stat_next_o | output | 32 | Status word with exception and accrued bits applied |
| stat_q_o | output | 32 | Registered status writeback |

## Verification
The hardest case to reach is one where the NaN and zero flags are both set. The result then depends on the order in which the zero term and the NaN term are combined. The same applies to a status word that already carries the branch-on-unordered bit while an IEEE-aware predicate is evaluated.

The stimulus sweeps every 6-bit predicate against all sixteen combinations of the four condition flags. On each step it also varies the prior exception bits and the update strobe. This exercises every case, including both of the above.

// File: rtl/fp_cond_pkg.sv
package fp_cond_pkg;

   typedef enum logic [1:0] {
      SGN_NONE = 2'b00,
      SGN_POS  = 2'b01,
      SGN_NEG  = 2'b10,
      SGN_ANY  = 2'b11
   } sign_sel_e;

   typedef struct packed {
      logic      legal;
      logic      unaware;
      logic      nan_or;
      sign_sel_e sgn;
      logic      zero_or;
   } pred_fields_t;

endpackage

// File: rtl/fp_pred_decode.sv
module fp_pred_decode
   import fp_cond_pkg::*;
#(
   parameter int PRED_W = 6
) (
   input  logic [PRED_W-1:0] pred,
   output pred_fields_t      fields
);

   localparam int COND_W = 5;

   logic legal;

   generate
      if (PRED_W < COND_W) begin : g_bad
         $error("fp_pred_decode: PRED_W must be at least 5");
         assign legal = 1'b0;
      end else if (PRED_W == COND_W) begin : g_nohi
         assign legal = 1'b1;
      end else begin : g_hi
         assign legal = (pred[PRED_W-1:COND_W] == '0);
      end
   endgenerate

   always_comb begin
      fields.legal   = legal;
      fields.unaware = pred[4];
      fields.nan_or  = pred[3];
      fields.sgn     = sign_sel_e'(pred[2:1]);
      fields.zero_or = pred[0];
   end

endmodule

// File: rtl/fp_pred_logic.sv
module fp_pred_logic
   import fp_cond_pkg::*;
(
   input  pred_fields_t fields,
   input  logic         flag_nan,
   input  logic         flag_neg,
   input  logic         flag_zero,
   output logic         result
);

   logic base_t;
   logic sign_t;
   logic and_t;
   logic zero_t;

   always_comb begin
      base_t = fields.nan_or ? 1'b1 : ~flag_nan;
      unique case (fields.sgn)
         SGN_NONE: sign_t = 1'b0;
         SGN_POS:  sign_t = ~flag_neg;
         SGN_NEG:  sign_t = flag_neg;
         default:  sign_t = 1'b1;
      endcase
      and_t  = base_t & sign_t;
      zero_t = fields.zero_or ? (and_t | flag_zero) : (and_t & ~flag_zero);
      result = fields.legal & (zero_t | (fields.nan_or & flag_nan));
   end

endmodule

// File: rtl/fp_stat_update.sv
module fp_stat_update #(
   parameter int STAT_W   = 32,
   parameter int BSUN_BIT = 15,
   parameter int AIOP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_in,
   input  logic              legal,
   input  logic              unaware,
   input  logic              flag_nan,
   input  logic              wr_en,
   output logic [STAT_W-1:0] stat_next,
   output logic [STAT_W-1:0] stat_q
);

   logic raise_bsun;
   logic bsun_now;

   always_comb begin
      raise_bsun = legal & unaware & flag_nan;
      bsun_now   = stat_in[BSUN_BIT] | raise_bsun;
      stat_next  = stat_in;
      if (legal) begin
         stat_next[BSUN_BIT] = bsun_now;
         if (bsun_now) stat_next[AIOP_BIT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                stat_q <= '0;
      else if (wr_en && legal)   stat_q <= stat_next;
   end

endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
   import fp_cond_pkg::*;
#(
   parameter int PRED_W   = 6,
   parameter int STAT_W   = 32,
   parameter int NEG_BIT  = 27,
   parameter int ZERO_BIT = 26,
   parameter int NAN_BIT  = 24,
   parameter int BSUN_BIT = 15,
   parameter int AIOP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRED_W-1:0] pred_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic              update_i,
   output logic              cond_true_o,
   output logic              illegal_o,
   output logic [STAT_W-1:0] stat_next_o,
   output logic [STAT_W-1:0] stat_q_o
);

   localparam int MAX_BIT = STAT_W - 1;

   generate
      if (NEG_BIT > MAX_BIT || ZERO_BIT > MAX_BIT || NAN_BIT > MAX_BIT ||
          BSUN_BIT > MAX_BIT || AIOP_BIT > MAX_BIT) begin : g_range_chk
         $error("fp_cond_eval: a flag position lies outside the status word");
      end
      if (NEG_BIT == ZERO_BIT || NEG_BIT == NAN_BIT || ZERO_BIT == NAN_BIT ||
          BSUN_BIT == AIOP_BIT) begin : g_overlap_chk
         $error("fp_cond_eval: flag positions overlap");
      end
   endgenerate

   pred_fields_t fields;
   logic         flag_nan;

   assign flag_nan  = stat_i[NAN_BIT];
   assign illegal_o = ~fields.legal;

   fp_pred_decode #(.PRED_W(PRED_W)) u_decode (
      .pred   (pred_i),
      .fields (fields)
   );

   fp_pred_logic u_logic (
      .fields    (fields),
      .flag_nan  (flag_nan),
      .flag_neg  (stat_i[NEG_BIT]),
      .flag_zero (stat_i[ZERO_BIT]),
      .result    (cond_true_o)
   );

   fp_stat_update #(
      .STAT_W   (STAT_W),
      .BSUN_BIT (BSUN_BIT),
      .AIOP_BIT (AIOP_BIT)
   ) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_in   (stat_i),
      .legal     (fields.legal),
      .unaware   (fields.unaware),
      .flag_nan  (flag_nan),
      .wr_en     (update_i),
      .stat_next (stat_next_o),
      .stat_q    (stat_q_o)
   );

   assert_illegal_false_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !cond_true_o);

   assert_illegal_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (update_i && illegal_o) |=> $stable(stat_q_o));

   assert_nan_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!illegal_o && pred_i[3] && stat_i[NAN_BIT]) |-> cond_true_o);

   assert_never_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!illegal_o && pred_i[3:0] == 4'h0) |-> !cond_true_o);

   assert_unordered_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!illegal_o && pred_i[4] && stat_i[NAN_BIT]) |-> stat_next_o[BSUN_BIT]);

   assert_accrued_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q_o[BSUN_BIT] |-> stat_q_o[AIOP_BIT]);

   assert_hold_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !update_i |=> $stable(stat_q_o));

endmodule

// File: tb/fp_cond_eval_bench.sv
`timescale 1ns/100ps
module fp_cond_eval_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  pred_i = '0;
   logic [31:0] stat_i = '0;
   logic        update_i = 1'b0;
   logic        cond_true_o;
   logic        illegal_o;
   logic [31:0] stat_next_o;
   logic [31:0] stat_q_o;

   int checks = 0;
   int failures = 0;
   logic [31:0] model_q = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fp_cond_eval u_fp_cond_eval (
      .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .stat_i(stat_i),
      .update_i(update_i), .cond_true_o(cond_true_o), .illegal_o(illegal_o),
      .stat_next_o(stat_next_o), .stat_q_o(stat_q_o)
   );

   // Condition meaning per code, written from the requirement text
   function automatic bit ref_cond(input logic [3:0] c, input bit n, input bit z, input bit nan);
      case (c)
         4'h0: return 1'b0;
         4'h1: return z;
         4'h2: return !nan && !n && !z;
         4'h3: return z || (!nan && !n);
         4'h4: return !nan && n && !z;
         4'h5: return z || (!nan && n);
         4'h6: return !nan && !z;
         4'h7: return z || !nan;
         4'h8: return nan;
         4'h9: return nan || z;
         4'hA: return nan || (!n && !z);
         4'hB: return nan || z || !n;
         4'hC: return nan || (n && !z);
         4'hD: return nan || z || n;
         4'hE: return nan || !z;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [31:0] ref_stat(input logic [5:0] p, input logic [31:0] s);
      logic [31:0] r;
      r = s;
      if (p >= 6'h20) return r;
      if (p[4] && s[24]) r[15] = 1'b1;
      if (r[15]) r[7] = 1'b1;
      return r;
   endfunction

   function automatic string cond_tag(input logic [5:0] p);
      if (p[5]) return "R1";
      if (p[4]) return "R12";
      if (p[3:0] == 4'h0 || p[3:0] == 4'hF || p[3:0] == 4'h1 || p[3:0] == 4'hE) return "R7";
      if (p[3]) return "R4/R5/R6";
      return "R3/R5/R6";
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // Drive at the falling edge, check combinational outputs, then let the edge load
   task automatic step(input logic [5:0] p, input logic [31:0] s, input bit upd);
      bit       exp_c;
      bit       exp_ill;
      logic [31:0] exp_n;
      @(negedge clk);
      check(stat_q_o === model_q, upd ? "R11" : "R2/R11", stat_q_o, model_q);
      pred_i = p; stat_i = s; update_i = upd;
      #1;
      exp_ill = (p >= 6'h20);
      exp_c   = exp_ill ? 1'b0 : ref_cond(p[3:0], s[27], s[26], s[24]);
      exp_n   = ref_stat(p, s);
      check(illegal_o === exp_ill, "R1", {31'd0, illegal_o}, {31'd0, exp_ill});
      check(cond_true_o === exp_c, cond_tag(p), {31'd0, cond_true_o}, {31'd0, exp_c});
      check(stat_next_o === exp_n, exp_ill ? "R2" : (p[4] ? "R8/R9" : "R9/R10"), stat_next_o, exp_n);
      @(posedge clk);
      if (upd && !exp_ill) model_q = exp_n;
   endtask

   initial begin
      #20000000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(stat_q_o === 32'h0, "R11", stat_q_o, 32'h0);  // reset state
      rst_n = 1'b1;

      // Exhaustive sweep of predicates against every flag combination (R3..R10, R12)
      for (int p = 0; p < 64; p++) begin
         for (int f = 0; f < 16; f++) begin
            logic [31:0] s;
            s = 32'h0000_1234 ^ (32'(p) << 8) ^ (32'(f) << 28);
            s[27] = f[3]; s[26] = f[2]; s[25] = f[1]; s[24] = f[0];
            s[15] = (p % 3 == 0) && f[1];
            s[7]  = (p % 5 == 0);
            step(6'(p), s, ((p + f) % 2) == 0);
         end
      end

      // R2: illegal strobe after a legal load must not move the register
      step(6'h18, 32'h0100_0000, 1'b1);
      step(6'h3F, 32'hFFFF_FFFF, 1'b1);
      step(6'h20, 32'h0000_0000, 1'b1);
      // R11: no strobe holds
      step(6'h1E, 32'h0100_0000, 1'b0);
      // R10: aware predicate passes an existing bit 15 and raises accrued bit 7
      step(6'h0E, 32'h0100_8000, 1'b1);
      step(6'h00, 32'h0000_0000, 1'b0);

      @(negedge clk);
      check(stat_q_o === model_q, "R11", stat_q_o, model_q);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule